// File: doc/BRIEF.md
# Power Controller Protection Supervisor

This block decides, cycle by cycle, whether the PWM generator of an offline switching controller may drive its gate. Its inputs are digital flags from analog comparators and a slow timer tick. Two flags describe the supply: one says it is above the start level, the other says it is below the stop level. The remaining flags report overvoltage on the supply, feedback overload and feedback pulled low for a remote shutdown. The block drives a switch enable and a three-bit state code.

Startup and shutdown follow the supply with hysteresis. An overvoltage stops switching immediately and holds it off until the supply has collapsed and risen again, so a fault that persists becomes a hiccup cycle. An overload must last for a set number of timer ticks before it latches a shutdown, which lets power-on and power-off transients pass. The overload latch clears only when the supply collapses. A remote-off request gates the output only for as long as it is asserted.

All comparator flags pass through synchronizer chains. The tick input must already be a one-cycle pulse in the clock domain.

Top module: `prot_supervisor`

## Requirements
- R1: During and right after reset, `state_o` is OFF (code 0) and `sw_en_o` is 0.
- R2: From OFF, a high `vcc_on_i` with `vcc_low_i` low moves the block to RUN (code 1) with `sw_en_o` = 1. `sw_en_o` is 1 only in RUN.
- R3: `vcc_low_i` high takes every state to OFF. In RUN, a fall of `vcc_on_i` alone does not stop switching. Once in OFF, the block stays there until `vcc_on_i` is high again.
- R4: `ovp_i` high in RUN or remote-off gives OVP_LATCHED (code 2) with the gate off. The state holds after `ovp_i` falls and leaves only through OFF.
- R5: After a restart from OFF, a persistent `ovp_i` gives RUN for one cycle and then OVP_LATCHED again (hiccup). If `ovp_i` is gone, RUN persists.
- R6: While `ovl_i` stays high in RUN, the OLP_TICKS-th `tick_i` pulse (default 10) gives OLP_LATCHED (code 3) with the gate off.
- R7: A low synchronized `ovl_i` restarts the tick count. Fewer than OLP_TICKS ticks in one unbroken overload cause no shutdown.
- R8: OLP_LATCHED holds after `ovl_i` falls and is cleared only by `vcc_low_i`, through OFF.
- R9: `roff_i` high in RUN gives REMOTE_OFF (code 4) with the gate off. Its release returns the block to RUN.
- R10: Priority: `vcc_low_i` over `ovp_i`, then the overload timeout, then `roff_i`.
- R11: A change on a comparator flag reaches `state_o` on the third rising clock edge after it is applied (two synchronizer stages plus the state register), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above start level (async) |
| vcc_low_i | input | 1 | Supply below stop level (async) |
| ovp_i | input | 1 | Supply overvoltage (async) |
| ovl_i | input | 1 | Feedback above overload level (async) |
| roff_i | input | 1 | Feedback pulled low, remote off (async) |
| tick_i | input | 1 | One-cycle delay timer tick, synchronous |
| sw_en_o | output | 1 | Switching enable for the PWM generator |
| state_o | output | 3 | State code: 0 OFF, 1 RUN, 2 OVP_LATCHED, 3 OLP_LATCHED, 4 REMOTE_OFF |

## Verification
The bench builds the block with the defaults: OLP_TICKS of 10 and a two-stage synchronizer. With these values the overload boundary falls at nine ticks (no trip) and ten ticks (trip), and the tests reach both. Every flag needs three edges to take effect, so the bench can check the cycle before the change and the cycle of the change itself. With the short tick window, an interrupted overload and a full one both fit in a short directed run.

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
  parameter int OLP_TICKS = 10,
  parameter int SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_low_i,
  input  logic       ovp_i,
  input  logic       ovl_i,
  input  logic       roff_i,
  input  logic       tick_i,
  output logic       sw_en_o,
  output logic [2:0] state_o
);
  localparam int CW = $clog2(OLP_TICKS + 1);
  localparam logic [2:0] ST_OFF  = 3'd0;
  localparam logic [2:0] ST_RUN  = 3'd1;
  localparam logic [2:0] ST_OVP  = 3'd2;
  localparam logic [2:0] ST_OLP  = 3'd3;
  localparam logic [2:0] ST_ROFF = 3'd4;

  logic [4:0] sync_q [SYNC_LEN];
  logic s_on, s_low, s_ovp, s_ovl, s_roff;
  logic [CW-1:0] cnt_q;
  logic olp_hit;
  logic [2:0] st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_LEN; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {roff_i, ovl_i, ovp_i, vcc_low_i, vcc_on_i};
      for (int i = 1; i < SYNC_LEN; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_roff, s_ovl, s_ovp, s_low, s_on} = sync_q[SYNC_LEN-1];

  assign olp_hit = s_ovl && tick_i && (cnt_q == CW'(OLP_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (st_q != ST_RUN || !s_ovl) cnt_q <= '0;
    else if (tick_i)                   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    if (s_low) st_d = ST_OFF;
    else begin
      case (st_q)
        ST_OFF:  if (s_on) st_d = ST_RUN;
        ST_RUN:  if (s_ovp) st_d = ST_OVP;
                 else if (olp_hit) st_d = ST_OLP;
                 else if (s_roff) st_d = ST_ROFF;
        ST_ROFF: if (s_ovp) st_d = ST_OVP;
                 else if (!s_roff) st_d = ST_RUN;
        ST_OVP, ST_OLP: st_d = st_q;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign sw_en_o = (st_q == ST_RUN);
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       sw_en_o,
  input logic [2:0] state_o
);
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  p_off_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd0 |=> (state_o == 3'd0 || state_o == 3'd1));

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd1 |-> !sw_en_o);

  p_ovp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd2 |=> (state_o == 3'd2 || state_o == 3'd0));

  p_olp_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && $past(state_o) == 3'd1) |-> $past(tick_i));

  p_olp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd3 |=> (state_o == 3'd3 || state_o == 3'd0));

  p_roff_no_olp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd4 |=> state_o != 3'd3);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (.*);

// File: tb/tb_prot_supervisor.sv
module tb_prot_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NTICK = 10;

  logic clk = 0, rst_n = 0;
  logic vcc_on = 0, vcc_low = 0, ovp = 0, ovl = 0, roff = 0, tick = 0;
  logic sw_en;
  logic [2:0] state;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_supervisor #(.OLP_TICKS(NTICK), .SYNC_LEN(2)) dut (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_low_i(vcc_low),
    .ovp_i(ovp), .ovl_i(ovl), .roff_i(roff), .tick_i(tick),
    .sw_en_o(sw_en), .state_o(state));

  task automatic chk(input logic [2:0] exp, input string req);
    total++;
    if (state !== exp || sw_en !== (exp == 3'd1)) begin
      bad++;
      $display("FAIL %s: state=%0d en=%0b expected state=%0d en=%0b",
               req, state, sw_en, exp, exp == 3'd1);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic supply(input logic on, input logic low);
    @(negedge clk);
    vcc_on = on; vcc_low = low;
    settle();
  endtask

  task automatic t_reset();
    #1 chk(3'd0, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(3'd0, "R1 after reset");
  endtask

  task automatic t_power();
    @(negedge clk) vcc_on = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk(3'd0, "R11 not before third edge");
    @(posedge clk);
    @(negedge clk) chk(3'd1, "R11 R2 on third edge");
    supply(0, 0); chk(3'd1, "R3 hysteresis holds run");
    supply(0, 1); chk(3'd0, "R3 low stops");
    supply(0, 0); chk(3'd0, "R3 stays off without start");
    supply(1, 0); chk(3'd1, "R2 restart");
  endtask

  task automatic t_ovp();
    @(negedge clk) ovp = 1;
    settle(); chk(3'd2, "R4 ovp trips");
    @(negedge clk) ovp = 0;
    settle(); chk(3'd2, "R4 ovp latched");
    supply(0, 1); chk(3'd0, "R4 cleared by low");
    supply(1, 0); chk(3'd1, "R5 recovers when cause gone");
    @(negedge clk) ovp = 1;
    settle(); chk(3'd2, "R5 trip again");
    supply(0, 1); chk(3'd0, "R5 hiccup off");
    @(negedge clk) begin vcc_on = 1; vcc_low = 0; end
    settle(); chk(3'd1, "R5 hiccup restart");
    @(posedge clk);
    @(negedge clk) chk(3'd2, "R5 hiccup retrip");
    @(negedge clk) ovp = 0;
    supply(0, 1);
    supply(1, 0); chk(3'd1, "R5 normal after hiccup");
  endtask

  task automatic t_olp();
    @(negedge clk) ovl = 1;
    settle();
    pulses(NTICK - 1); chk(3'd1, "R7 short overload");
    @(negedge clk) ovl = 0;
    settle();
    @(negedge clk) ovl = 1;
    settle();
    pulses(NTICK - 1); chk(3'd1, "R7 count restarted");
    pulses(1); chk(3'd3, "R6 overload trips on last tick");
    @(negedge clk) ovl = 0;
    settle(); chk(3'd3, "R8 overload latched");
    supply(1, 1); chk(3'd0, "R8 cleared by low");
    supply(1, 0); chk(3'd1, "R8 restart after clear");
  endtask

  task automatic t_roff();
    @(negedge clk) roff = 1;
    settle(); chk(3'd4, "R9 remote off");
    @(negedge clk) roff = 0;
    settle(); chk(3'd1, "R9 release resumes");
    @(negedge clk) roff = 1;
    settle();
    supply(1, 1); chk(3'd0, "R10 low beats remote off");
    @(negedge clk) roff = 0;
    supply(1, 0); chk(3'd1, "R10 back to run");
    @(negedge clk) begin ovp = 1; roff = 1; ovl = 1; end
    settle(); chk(3'd2, "R10 ovp beats remote off");
    @(negedge clk) begin ovp = 0; roff = 0; ovl = 0; end
    supply(0, 1); chk(3'd0, "R10 low clears");
  endtask

  initial begin
    t_reset();
    t_power();
    t_ovp();
    t_olp();
    t_roff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule